// File: doc/BRIEF.md
# DMA Chunk-Request Handshake Unit

This block decides, for every channel of a multi-channel DMA controller, whether a source-side or destination-side chunk transaction is being requested. It then presents those requests to the per-channel transfer engines. Each side of each channel is served in one of three ways:
- **Software handshaking.** A request is posted by writing to a shared, self-clearing request register.
- **Hardware handshaking.** A request comes from a dedicated peripheral request line.
- **Memory side.** The side needs no handshake at all and requests continuously while its channel is enabled.

A small register port gives software access to the request register and to the per-side configuration. Completion strobes from the engines retire software requests. A per-side flow-control bit decides whether the peripheral's last-transaction line is passed on to the engine or ignored.

Top module: `dhr_unit`

## Requirements
- R1: After reset, all of the following hold:
  - every pending request bit is 0;
  - every side selects hardware handshaking (select register all ones);
  - the memory-side, flow-control and channel-enable registers are 0;
  - `eng_req_o` and `eng_last_o` are 0.
- R2: Side index `2x` is the source side of channel `x`, and `2x+1` is its destination side. This layout applies to the request, select, memory-side and flow-control registers and to `hw_req_i`, `hw_last_i`, `done_i`, `eng_req_o` and `eng_last_o`. A 1 written to a request bit of a software-handshaking side sets that bit. The next cycle, the matching `eng_req_o` bit is 1.
- R3: Writing 1 to a request bit that is already set leaves it set and queues nothing. A single completion clears it.
- R4: A `done_i` pulse on a side clears that side's request bit. From the next cycle, the matching `eng_req_o` bit is 0.
- R5: Writing 0 to a request bit leaves it unchanged.
- R6: If a write sets a bit in the same cycle that `done_i` clears it, the bit ends at 0. A later write sets it again.
- R7: On a side whose select bit is 1 (hardware), `eng_req_o` equals the value `hw_req_i` had one cycle earlier. Writes to that side's request bit are ignored.
- R8: On a side whose memory-side bit is 1, `eng_req_o` equals the enable bit of its channel, regardless of the select bit and `hw_req_i`. Writes to that side's request bit are ignored.
- R9: `eng_last_o` for a side equals the registered `hw_last_i` when that side's flow-control bit is 1, and is 0 otherwise.
- R10: The register port is laid out as follows.

  | Address | Register | Width | Access |
  |---|---|---|---|
  | 0 | request | 2·NUM_CH | read returns pending bits |
  | 1 | select | 2·NUM_CH | write / read back |
  | 2 | memory-side | 2·NUM_CH | write / read back |
  | 3 | flow-control | 2·NUM_CH | write / read back |
  | 4 | channel enable | NUM_CH (bit `x` = channel `x`) | write / read back |

  All other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 2*NUM_CH | Write data |
| reg_rdata_o | output | 2*NUM_CH | Read data for `reg_addr_i` (combinational) |
| hw_req_i | input | 2*NUM_CH | Peripheral chunk request per side |
| hw_last_i | input | 2*NUM_CH | Peripheral last-transaction flag per side |
| done_i | input | 2*NUM_CH | Engine completion strobe per side |
| eng_req_o | output | 2*NUM_CH | Chunk request to engines per side |
| eng_last_o | output | 2*NUM_CH | Last-transaction flag to engines per side |

## Verification
A software write that sets a request bit and an engine completion strobe that clears the same bit can arrive in one cycle. The bench provokes this by driving the write and the `done_i` pulse on the same clock edge. It judges the outcome by reading the request register afterwards and expecting 0. A fresh write must then set the bit again, which shows that nothing was lost or queued.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
   typedef enum logic [2:0] {
      DHR_A_REQ   = 3'd0,
      DHR_A_HWSEL = 3'd1,
      DHR_A_MEM   = 3'd2,
      DHR_A_FLOW  = 3'd3,
      DHR_A_EN    = 3'd4
   } dhr_addr_e;
endpackage

// File: rtl/dhr_cfg_regs.sv
module dhr_cfg_regs
   import dhr_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int SIDE_W = 2 * NUM_CH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [2:0]        addr_i,
   input  logic [SIDE_W-1:0] wdata_i,
   output logic [SIDE_W-1:0] hwsel_o,
   output logic [SIDE_W-1:0] mem_o,
   output logic [SIDE_W-1:0] flow_o,
   output logic [NUM_CH-1:0] en_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hwsel_o <= '1;
         mem_o   <= '0;
         flow_o  <= '0;
         en_o    <= '0;
      end else if (wr_i) begin
         case (addr_i)
            DHR_A_HWSEL: hwsel_o <= wdata_i;
            DHR_A_MEM:   mem_o   <= wdata_i;
            DHR_A_FLOW:  flow_o  <= wdata_i;
            DHR_A_EN:    en_o    <= wdata_i[NUM_CH-1:0];
            default: ;
         endcase
      end
   end

   AST_CFG_RESET_HW: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> (hwsel_o == '1 && mem_o == '0 && en_o == '0)); // R1
endmodule

// File: rtl/dhr_side.sv
module dhr_side (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_wr_i,
   input  logic req_bit_i,
   input  logic hwsel_i,
   input  logic mem_i,
   input  logic flow_i,
   input  logic ch_en_i,
   input  logic hw_req_i,
   input  logic hw_last_i,
   input  logic done_i,
   output logic pend_o,
   output logic req_o,
   output logic last_o
);
   logic hw_req_q, hw_last_q, past_ok, set_ok;

   assign set_ok = req_wr_i & req_bit_i & ~hwsel_i & ~mem_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o    <= 1'b0;
         hw_req_q  <= 1'b0;
         hw_last_q <= 1'b0;
         past_ok   <= 1'b0;
      end else begin
         past_ok   <= 1'b1;
         hw_req_q  <= hw_req_i;
         hw_last_q <= hw_last_i;
         if (done_i)      pend_o <= 1'b0;
         else if (set_ok) pend_o <= 1'b1;
      end
   end

   always_comb begin
      if (mem_i)        req_o = ch_en_i;
      else if (hwsel_i) req_o = hw_req_q;
      else              req_o = pend_o;
   end

   assign last_o = flow_i & hw_last_q;

   AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !pend_o); // R4
   AST_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_wr_i && !req_bit_i && !done_i) |=> pend_o == $past(pend_o)); // R5
   AST_HW_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && hwsel_i && !mem_i) |-> req_o == $past(hw_req_i)); // R7
   AST_HW_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_wr_i && req_bit_i && (hwsel_i || mem_i) && !pend_o) |=> !pend_o); // R7
   AST_MEM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_i |-> req_o == ch_en_i); // R8
   AST_LAST_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flow_i |-> !last_o); // R9
endmodule

// File: rtl/dhr_unit.sv
module dhr_unit
   import dhr_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int SIDE_W = 2 * NUM_CH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [2:0]        reg_addr_i,
   input  logic [SIDE_W-1:0] reg_wdata_i,
   output logic [SIDE_W-1:0] reg_rdata_o,
   input  logic [SIDE_W-1:0] hw_req_i,
   input  logic [SIDE_W-1:0] hw_last_i,
   input  logic [SIDE_W-1:0] done_i,
   output logic [SIDE_W-1:0] eng_req_o,
   output logic [SIDE_W-1:0] eng_last_o
);
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_num_ch
      $error("dhr_unit: NUM_CH must be within 1..16");
   end

   logic [SIDE_W-1:0] hwsel, mem, flow, pend;
   logic [NUM_CH-1:0] en;
   logic              req_wr;

   assign req_wr = reg_wr_i && (reg_addr_i == DHR_A_REQ);

   dhr_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .hwsel_o (hwsel),
      .mem_o   (mem),
      .flow_o  (flow),
      .en_o    (en)
   );

   for (genvar s = 0; s < SIDE_W; s++) begin : g_side
      localparam int CH = s / 2;
      dhr_side u_side (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .req_wr_i  (req_wr),
         .req_bit_i (reg_wdata_i[s]),
         .hwsel_i   (hwsel[s]),
         .mem_i     (mem[s]),
         .flow_i    (flow[s]),
         .ch_en_i   (en[CH]),
         .hw_req_i  (hw_req_i[s]),
         .hw_last_i (hw_last_i[s]),
         .done_i    (done_i[s]),
         .pend_o    (pend[s]),
         .req_o     (eng_req_o[s]),
         .last_o    (eng_last_o[s])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         DHR_A_REQ:   reg_rdata_o = pend;
         DHR_A_HWSEL: reg_rdata_o = hwsel;
         DHR_A_MEM:   reg_rdata_o = mem;
         DHR_A_FLOW:  reg_rdata_o = flow;
         DHR_A_EN:    reg_rdata_o[NUM_CH-1:0] = en;
         default: ;
      endcase
   end

   AST_NO_SET_WHILE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_wr && done_i != '0) |=> ((pend & $past(done_i)) == '0)); // R6
endmodule

// File: tb/dhr_unit_tb.sv
module dhr_unit_tb;
   localparam int NCH = 4;
   localparam int SW  = 2 * NCH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [2:0]    addr = '0;
   logic [SW-1:0] wdata = '0, rdata, hw_req = '0, hw_last = '0, done = '0;
   logic [SW-1:0] eng_req, eng_last;
   int            n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   dhr_unit #(.NUM_CH(NCH)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hw_req_i(hw_req),
      .hw_last_i(hw_last), .done_i(done), .eng_req_o(eng_req),
      .eng_last_o(eng_last)
   );

   task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [SW-1:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; wdata = '0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [SW-1:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic pulse_done(input logic [SW-1:0] m);
      @(negedge clk); done = m;
      @(negedge clk); done = '0;
   endtask

   task automatic t_reset;
      logic [SW-1:0] v;
      rreg(3'd0, v); chk("R1 req reg", v, '0);
      rreg(3'd1, v); chk("R1 select reg", v, '1);
      rreg(3'd2, v); chk("R1 mem reg", v, '0);
      rreg(3'd3, v); chk("R1 flow reg", v, '0);
      rreg(3'd4, v); chk("R1 enable reg", v, '0);
      chk("R1 eng_req", eng_req, '0);
      chk("R1 eng_last", eng_last, '0);
   endtask

   task automatic t_sw_set;
      logic [SW-1:0] v;
      wreg(3'd1, '0);
      wreg(3'd0, 8'h04);                 // ch1 source
      rreg(3'd0, v); chk("R10 read pending", v, 8'h04);
      chk("R2 ch1 src req", eng_req, 8'h04);
      wreg(3'd0, 8'h20);                 // ch2 destination
      rreg(3'd0, v); chk("R2 ch2 dst added", v, 8'h24);
      chk("R2 eng_req two sides", eng_req, 8'h24);
   endtask

   task automatic t_zero_write;
      logic [SW-1:0] v;
      wreg(3'd0, 8'h00);
      rreg(3'd0, v); chk("R5 zero write", v, 8'h24);
   endtask

   task automatic t_reset_again;
      logic [SW-1:0] v;
      wreg(3'd0, 8'h04);
      rreg(3'd0, v); chk("R3 re-set keeps", v, 8'h24);
      pulse_done(8'h04);
      rreg(3'd0, v); chk("R4 done clears", v, 8'h20);
      chk("R3 no queued request", eng_req, 8'h20);
   endtask

   task automatic t_collide;
      logic [SW-1:0] v;
      @(negedge clk); wr = 1'b1; addr = 3'd0; wdata = 8'h01; done = 8'h01;
      @(negedge clk); wr = 1'b0; wdata = '0; done = '0;
      rreg(3'd0, v); chk("R6 clear wins", v, 8'h20);
      wreg(3'd0, 8'h01);
      rreg(3'd0, v); chk("R6 later set", v, 8'h21);
      pulse_done(8'hFF);
      rreg(3'd0, v); chk("R4 all cleared", v, 8'h00);
   endtask

   task automatic t_hw;
      logic [SW-1:0] v;
      wreg(3'd1, 8'hFF);
      @(negedge clk); hw_req = 8'h5A;
      #1; chk("R7 not same cycle", eng_req, 8'h00);
      @(negedge clk); chk("R7 follows hw", eng_req, 8'h5A);
      wreg(3'd0, 8'hFF);
      rreg(3'd0, v); chk("R7 write ignored", v, 8'h00);
      hw_req = 8'h00;
      @(negedge clk); chk("R7 hw drop", eng_req, 8'h00);
   endtask

   task automatic t_mem;
      logic [SW-1:0] v;
      wreg(3'd2, 8'h03);                 // ch0 both sides memory
      chk("R8 disabled", eng_req, 8'h00);
      wreg(3'd4, 8'h01);
      chk("R8 enabled", eng_req, 8'h03);
      wreg(3'd1, 8'h00);
      wreg(3'd0, 8'h03);
      rreg(3'd0, v); chk("R8 write ignored", v, 8'h00);
      chk("R8 still on", eng_req, 8'h03);
   endtask

   task automatic t_last;
      logic [SW-1:0] v;
      @(negedge clk); hw_last = 8'hFF;
      @(negedge clk); chk("R9 ignored w/o flow", eng_last, 8'h00);
      wreg(3'd3, 8'h0C);
      chk("R9 passed with flow", eng_last, 8'h0C);
      rreg(3'd3, v); chk("R10 flow readback", v, 8'h0C);
      rreg(3'd5, v); chk("R10 unused addr", v, 8'h00);
   endtask

   initial begin
      #200000000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_set();
      t_zero_write();
      t_reset_again();
      t_collide();
      t_hw();
      t_mem();
      t_last();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule